// File: doc/BRIEF.md
# Boot Program Copy Engine

This block holds a small boot program in a 1 KiB memory that stays powered through sleep. It copies that program, one dword at a time, into the instruction memory of an embedded processor. Host software fills the boot memory through a host register window, sets a source byte offset, a destination byte address and a length in dwords, and then starts the copy by setting the top bit of the control register. That bit stays set while the copy runs and clears when the copy ends, so software can poll it. A status bit also shows that the copy has finished.

A second control bit arms the engine. While it is set, every power-up event replays the copy with the values held in the registers, and no software is involved. When a copy started by a power-up event ends, the engine gives a one-cycle processor-start pulse. A copy started by software gives no pulse. The destination side is a plain write port with a ready input. It accepts one dword per cycle while ready is high.

Host map (byte addresses): 0x00 control, 0x04 source offset, 0x08 destination address, 0x0C dword count, 0x10 status. Addresses 0x400 to 0x7FF are the boot memory.

Top module: `boot_copy_engine`

## Requirements
- R1: After reset, control and status read 0, `dst_we` is low and `cpu_start` is low.
- R2: All 256 dwords of the boot memory, at host addresses 0x400 + 4*k, can be written and read back unchanged.
- R3: Writing control with bit 31 set while idle starts a copy. Control bit 31 reads 1 and status bit 0 reads 0 while the copy runs. Control bit 31 reads 0 and status bit 0 reads 1 once it ends.
- R4: Beat i of a copy writes boot memory dword (source/4 + i) to `dst_addr` = destination + 4*i. A beat is accepted only in a cycle where `dst_ready` is high. While `dst_ready` is low, address and data hold.
- R5: A dword count of 0 performs no write. Control bit 31 reads 0 and status bit 0 reads 1 in the cycle after the start.
- R6: The number of beats is the smaller of the count and (1024 - source)/4. A source offset of 1024 or more gives zero beats.
- R7: Control bit 30 reads back as written. A `power_up_evt` pulse while bit 30 is set and the engine is idle starts the copy with the current register values. The pulse does nothing while bit 30 is clear.
- R8: `cpu_start` is high for exactly one cycle after a copy started by a power-up event ends. It never goes high for a copy started by software.
- R9: Writing control bit 31 while a copy runs is ignored. The running copy continues unchanged and no new copy starts.
- R10: The source, destination and count registers read back the values written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 11 | Host byte address (registers or boot memory) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for host_addr |
| power_up_evt | input | 1 | Power-up event pulse |
| dst_ready | input | 1 | Destination can accept a write this cycle |
| dst_we | output | 1 | Destination write valid |
| dst_addr | output | 32 | Destination byte address |
| dst_wdata | output | 32 | Destination write data |
| cpu_start | output | 1 | One-cycle processor-start pulse |

## Verification
The hardest case to reach from the ports is a start write that arrives in the middle of a long copy while the destination is throttling it. The copy has to be long, and `dst_ready` has to drop at random so the copy is still running when the second write lands. The stimulus sets up a 200-dword copy with `dst_ready` high only part of the time, writes the start bit again a few cycles in, and then checks that the full beat stream comes out exactly once. Random copies then mix source offsets near and past the end of memory, zero counts, and both ways of starting a copy.

// File: rtl/bcp_pkg.sv
package bcp_pkg;
  localparam int unsigned DW = 32;
  localparam logic [10:0] OFS_CTRL = 11'h000;
  localparam logic [10:0] OFS_SRC  = 11'h004;
  localparam logic [10:0] OFS_DST  = 11'h008;
  localparam logic [10:0] OFS_CNT  = 11'h00C;
  localparam logic [10:0] OFS_STAT = 11'h010;
  localparam int unsigned BIT_GO  = 31;
  localparam int unsigned BIT_ARM = 30;
  typedef enum logic {ST_IDLE = 1'b0, ST_COPY = 1'b1} seq_state_e;
endpackage

// File: rtl/bcp_bootmem.sv
module bcp_bootmem #(
  parameter int unsigned WORDS = 256,
  parameter int unsigned DW    = 32,
  localparam int unsigned IW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [IW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b
);
  // retention array, no reset: contents survive sleep
  logic [DW-1:0] mem_q [WORDS];

  always_ff @(posedge clk) begin
    if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata_a = mem_q[raddr_a];
  assign rdata_b = mem_q[raddr_b];
endmodule

// File: rtl/bcp_regs.sv
module bcp_regs
  import bcp_pkg::*;
#(
  parameter int unsigned AW    = 11,
  parameter int unsigned CNT_W = 16,
  parameter int unsigned IW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr,
  input  logic [AW-1:0]    host_addr,
  input  logic [DW-1:0]    host_wdata,
  output logic [DW-1:0]    host_rdata,
  input  logic             busy,
  input  logic             done,
  input  logic [DW-1:0]    mem_rdata,
  output logic             mem_we,
  output logic [IW-1:0]    mem_idx,
  output logic             go_req,
  output logic             arm,
  output logic [DW-1:0]    cfg_src,
  output logic [DW-1:0]    cfg_dst,
  output logic [CNT_W-1:0] cfg_cnt
);
  logic in_mem;
  logic wr_ctrl, wr_src, wr_dst, wr_cnt;
  logic arm_q;
  logic [DW-1:0]    src_q, dst_q;
  logic [CNT_W-1:0] cnt_q;

  assign in_mem  = host_addr[AW-1];
  assign mem_idx = host_addr[IW+1:2];
  assign mem_we  = host_wr && in_mem;
  assign wr_ctrl = host_wr && (host_addr == OFS_CTRL[AW-1:0]);
  assign wr_src  = host_wr && (host_addr == OFS_SRC[AW-1:0]);
  assign wr_dst  = host_wr && (host_addr == OFS_DST[AW-1:0]);
  assign wr_cnt  = host_wr && (host_addr == OFS_CNT[AW-1:0]);
  assign go_req  = wr_ctrl && host_wdata[BIT_GO];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q <= 1'b0;
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_ctrl) arm_q <= host_wdata[BIT_ARM];
      if (wr_src)  src_q <= host_wdata;
      if (wr_dst)  dst_q <= host_wdata;
      if (wr_cnt)  cnt_q <= host_wdata[CNT_W-1:0];
    end
  end

  assign arm     = arm_q;
  assign cfg_src = src_q;
  assign cfg_dst = dst_q;
  assign cfg_cnt = cnt_q;

  always_comb begin
    host_rdata = '0;
    if (in_mem) begin
      host_rdata = mem_rdata;
    end else begin
      unique case (host_addr)
        OFS_CTRL[AW-1:0]: begin
          host_rdata[BIT_GO]  = busy;
          host_rdata[BIT_ARM] = arm_q;
        end
        OFS_SRC[AW-1:0]:  host_rdata = src_q;
        OFS_DST[AW-1:0]:  host_rdata = dst_q;
        OFS_CNT[AW-1:0]:  host_rdata[CNT_W-1:0] = cnt_q;
        OFS_STAT[AW-1:0]: host_rdata[0] = done;
        default:          host_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/bcp_seq.sv
module bcp_seq
  import bcp_pkg::*;
#(
  parameter int unsigned WORDS = 256,
  parameter int unsigned CNT_W = 16,
  localparam int unsigned IW   = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_req,
  input  logic             pwr_evt,
  input  logic             arm,
  input  logic [DW-1:0]    cfg_src,
  input  logic [DW-1:0]    cfg_dst,
  input  logic [CNT_W-1:0] cfg_cnt,
  input  logic             dst_ready,
  output logic             busy,
  output logic             done,
  output logic             cpu_start,
  output logic [IW-1:0]    rd_idx,
  output logic             dst_we,
  output logic [DW-1:0]    dst_addr
);
  seq_state_e       state_q, state_d;
  logic [IW-1:0]    idx_q, idx_d;
  logic [DW-1:0]    dst_q, dst_d;
  logic [CNT_W-1:0] left_q, left_d;
  logic             auto_q, auto_d;
  logic             done_q, done_d;
  logic             pulse_q, pulse_d;

  logic             idle, go_sw, go_pw, go_any;
  logic             src_oob;
  logic [IW:0]      avail;
  logic [CNT_W-1:0] avail_ext, beats;

  assign idle    = (state_q == ST_IDLE);
  assign go_sw   = idle && go_req;
  assign go_pw   = idle && pwr_evt && arm && !go_req;
  assign go_any  = go_sw || go_pw;
  assign src_oob = |cfg_src[DW-1:IW+2];
  assign avail   = src_oob ? '0 : ((IW+1)'(WORDS) - {1'b0, cfg_src[IW+1:2]});
  assign avail_ext = CNT_W'(avail);
  assign beats   = (cfg_cnt < avail_ext) ? cfg_cnt : avail_ext;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    dst_d   = dst_q;
    left_d  = left_q;
    auto_d  = auto_q;
    done_d  = done_q;
    pulse_d = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (go_any) begin
          if (beats == '0) begin
            done_d  = 1'b1;
            pulse_d = go_pw;
          end else begin
            state_d = ST_COPY;
            idx_d   = cfg_src[IW+1:2];
            dst_d   = cfg_dst;
            left_d  = beats;
            auto_d  = go_pw;
            done_d  = 1'b0;
          end
        end
      end
      ST_COPY: begin
        if (dst_ready) begin
          idx_d  = idx_q + 1'b1;
          dst_d  = dst_q + 32'd4;
          left_d = left_q - 1'b1;
          if (left_q == CNT_W'(1)) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
            pulse_d = auto_q;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      dst_q   <= '0;
      left_q  <= '0;
      auto_q  <= 1'b0;
      done_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      dst_q   <= dst_d;
      left_q  <= left_d;
      auto_q  <= auto_d;
      done_q  <= done_d;
      pulse_q <= pulse_d;
    end
  end

  assign busy      = (state_q == ST_COPY);
  assign done      = done_q;
  assign cpu_start = pulse_q;
  assign rd_idx    = idx_q;
  assign dst_we    = busy;
  assign dst_addr  = dst_q;
endmodule

// File: rtl/boot_copy_engine.sv
module boot_copy_engine
  import bcp_pkg::*;
#(
  parameter int unsigned WORDS = 256,
  parameter int unsigned CNT_W = 16,
  localparam int unsigned IW   = $clog2(WORDS),
  localparam int unsigned AW   = IW + 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  input  logic          power_up_evt,
  input  logic          dst_ready,
  output logic          dst_we,
  output logic [DW-1:0] dst_addr,
  output logic [DW-1:0] dst_wdata,
  output logic          cpu_start
);
  logic             busy, done, go_req, arm, mem_we;
  logic [IW-1:0]    host_idx, seq_idx;
  logic [DW-1:0]    host_mem_rd;
  logic [DW-1:0]    cfg_src, cfg_dst;
  logic [CNT_W-1:0] cfg_cnt;

  bcp_regs #(.AW(AW), .CNT_W(CNT_W), .IW(IW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata),
    .busy(busy), .done(done), .mem_rdata(host_mem_rd),
    .mem_we(mem_we), .mem_idx(host_idx), .go_req(go_req), .arm(arm),
    .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_cnt(cfg_cnt)
  );

  bcp_bootmem #(.WORDS(WORDS), .DW(DW)) u_mem (
    .clk(clk), .we(mem_we), .waddr(host_idx), .wdata(host_wdata),
    .raddr_a(host_idx), .rdata_a(host_mem_rd),
    .raddr_b(seq_idx), .rdata_b(dst_wdata)
  );

  bcp_seq #(.WORDS(WORDS), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .go_req(go_req), .pwr_evt(power_up_evt), .arm(arm),
    .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_cnt(cfg_cnt),
    .dst_ready(dst_ready),
    .busy(busy), .done(done), .cpu_start(cpu_start),
    .rd_idx(seq_idx), .dst_we(dst_we), .dst_addr(dst_addr)
  );
endmodule

// File: rtl/boot_copy_engine_chk.sv
module boot_copy_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        dst_we,
  input logic        dst_ready,
  input logic [31:0] dst_addr,
  input logic [31:0] dst_wdata,
  input logic        cpu_start
);
  // R8
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_start |=> !cpu_start);
  // R8
  start_after_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_start |-> !dst_we);
  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_we && !dst_ready) |=> (dst_we && $stable(dst_addr) && $stable(dst_wdata)));
  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_we && dst_ready) |=> (!dst_we || dst_addr == $past(dst_addr) + 32'd4));
endmodule

bind boot_copy_engine boot_copy_engine_chk i_chk (
  .clk(clk), .rst_n(rst_n), .dst_we(dst_we), .dst_ready(dst_ready),
  .dst_addr(dst_addr), .dst_wdata(dst_wdata), .cpu_start(cpu_start)
);

// File: tb/test_boot_copy_engine.sv
module test_boot_copy_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [10:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        power_up_evt = 1'b0;
  logic        dst_ready = 1'b1;
  logic        dst_we;
  logic [31:0] dst_addr, dst_wdata;
  logic        cpu_start;

  int errors = 0;
  int checks = 0;
  int ready_pct = 100;
  logic [31:0] model_mem [256];
  logic [31:0] log_addr [512];
  logic [31:0] log_data [512];
  int n_beats = 0;
  int n_pulses = 0;

  boot_copy_engine i_boot_copy_engine (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .power_up_evt(power_up_evt), .dst_ready(dst_ready), .dst_we(dst_we),
    .dst_addr(dst_addr), .dst_wdata(dst_wdata), .cpu_start(cpu_start)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    #1 dst_ready = (($urandom % 100) < ready_pct);
  end

  always @(negedge clk) begin
    if (dst_we && dst_ready && n_beats < 512) begin
      log_addr[n_beats] = dst_addr;
      log_data[n_beats] = dst_wdata;
      n_beats++;
    end
    if (cpu_start) n_pulses++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [10:0] a, input logic [31:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [10:0] a, output logic [31:0] d);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  function automatic int exp_beats(input logic [31:0] src, input int cnt);
    int avail;
    if (src >= 32'd1024) return 0;
    avail = (1024 - int'(src)) / 4;
    return (cnt < avail) ? cnt : avail;
  endfunction

  task automatic wait_idle();
    logic [31:0] v;
    int guard;
    guard = 0;
    do begin
      @(negedge clk);
      reg_read(11'h000, v);
      guard++;
    end while (v[31] && guard < 3000);
  endtask

  task automatic run_copy(input logic [31:0] src, input logic [31:0] dst, input int cnt,
                          input bit auto, input bit reissue);
    logic [31:0] v;
    int n;
    reg_write(11'h004, src);
    reg_write(11'h008, dst);
    reg_write(11'h00C, cnt);
    n = exp_beats(src, cnt);
    if (auto) reg_write(11'h000, 32'h4000_0000);
    n_beats = 0; n_pulses = 0;
    if (auto) begin
      @(negedge clk); power_up_evt = 1'b1;
      @(negedge clk); power_up_evt = 1'b0;
    end else begin
      reg_write(11'h000, 32'h8000_0000);
    end
    reg_read(11'h000, v);
    if (n > 0) begin
      chk(v[31] == 1'b1, "R3 busy bit during copy", v, 32'h8000_0000);
      reg_read(11'h010, v);
      chk(v == 32'd0, "R3 status during copy", v, 32'd0);
      if (reissue) begin
        repeat (5) @(negedge clk);
        reg_write(11'h000, 32'h8000_0000); // R9 start while running
      end
    end else begin
      chk(v[31] == 1'b0, "R5 zero copy not busy", v, 32'h0);
    end
    wait_idle();
    repeat (3) @(negedge clk);
    reg_read(11'h010, v);
    chk(v == 32'd1, n == 0 ? "R5 done after empty copy" : "R3 done after copy", v, 32'd1);
    chk(n_beats == n, reissue ? "R9 beat count" : "R6 beat count", n_beats, n);
    for (int i = 0; i < n && i < n_beats; i++) begin
      if (log_addr[i] != dst + 4 * i || log_data[i] != model_mem[(src >> 2) + i]) begin
        chk(1'b0, "R4 beat content", log_data[i], model_mem[(src >> 2) + i]);
        break;
      end
    end
    chk(n_pulses == (auto ? 1 : 0), auto ? "R8 one pulse for power-up copy" : "R8 no pulse for software copy",
        n_pulses, auto ? 1 : 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    reg_read(11'h000, v); chk(v == 0, "R1 control after reset", v, 0);
    reg_read(11'h010, v); chk(v == 0, "R1 status after reset", v, 0);
    chk(dst_we == 1'b0 && cpu_start == 1'b0, "R1 outputs idle", {dst_we, cpu_start}, 0);

    // R2 fill and read back the boot memory
    for (int k = 0; k < 256; k++) begin
      model_mem[k] = $urandom;
      reg_write(11'h400 + 11'(4 * k), model_mem[k]);
    end
    for (int k = 0; k < 256; k++) begin
      reg_read(11'h400 + 11'(4 * k), v);
      chk(v == model_mem[k], "R2 boot memory readback", v, model_mem[k]);
    end

    // R10 register readback
    reg_write(11'h004, 32'h0000_0120);
    reg_write(11'h008, 32'h0001_2340);
    reg_write(11'h00C, 32'h0000_0033);
    reg_read(11'h004, v); chk(v == 32'h120, "R10 source readback", v, 32'h120);
    reg_read(11'h008, v); chk(v == 32'h12340, "R10 destination readback", v, 32'h12340);
    reg_read(11'h00C, v); chk(v == 32'h33, "R10 count readback", v, 32'h33);

    // R7 arm bit readback and unarmed event
    reg_write(11'h000, 32'h4000_0000);
    reg_read(11'h000, v); chk(v == 32'h4000_0000, "R7 arm readback", v, 32'h4000_0000);
    reg_write(11'h000, 32'h0);
    n_beats = 0; n_pulses = 0;
    @(negedge clk); power_up_evt = 1'b1;
    @(negedge clk); power_up_evt = 1'b0;
    repeat (5) @(negedge clk);
    chk(n_beats == 0 && n_pulses == 0, "R7 unarmed event ignored", n_beats, 0);
    reg_read(11'h000, v); chk(v == 0, "R7 unarmed stays idle", v, 0);

    // directed copies
    run_copy(32'h0, 32'h1000, 16, 1'b0, 1'b0);       // R3 R4 software copy
    run_copy(32'h40, 32'h2000, 8, 1'b1, 1'b0);       // R7 R8 power-up copy
    run_copy(32'h10, 32'h3000, 0, 1'b0, 1'b0);       // R5 zero count
    run_copy(32'h10, 32'h3000, 0, 1'b1, 1'b0);       // R5 R8 zero count, power-up
    run_copy(32'h3F0, 32'h4000, 10, 1'b0, 1'b0);     // R6 stops at memory end
    run_copy(32'h400, 32'h4000, 10, 1'b1, 1'b0);     // R6 source out of range
    run_copy(32'h3FC, 32'h5000, 1, 1'b0, 1'b0);      // R6 last dword
    ready_pct = 40;
    run_copy(32'h0, 32'h6000, 200, 1'b0, 1'b1);      // R9 restart ignored under stalls
    run_copy(32'h20, 32'h7000, 30, 1'b1, 1'b1);      // R9 with power-up copy

    // random copies
    for (int t = 0; t < 24; t++) begin
      logic [31:0] s, d;
      int c;
      ready_pct = 30 + int'($urandom % 71);
      s = ($urandom % 260) * 4;
      d = $urandom & 32'hFFFF_FFFC;
      c = (($urandom % 5) == 0) ? 0 : int'($urandom % 300);
      run_copy(s, d, c, 1'($urandom % 2), 1'b0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule